// File: doc/BRIEF.md
# Comparator Edge Event Request Logic

This block samples the filtered output of an analog comparator once per bus clock. It keeps one sticky flag for upward transitions and one for downward transitions. Each flag is gated by its own enable bit, and the two gated terms are combined into a single service request.

That request goes to one of two places, chosen by a DMA mode bit. With DMA mode off it drives the CPU interrupt line. With DMA mode on it drives a transfer request to the DMA engine instead. In DMA mode, a completion pulse from the engine clears the flags that caused the request, which drops the request so that the next transition can raise a new one.

Software clears a flag by writing a one to its clear strobe. Flag setting and edge detection keep running in stop modes, provided the clock is still present.

Top module: `cmp_edge_req`

## Requirements
- R1: During and right after reset, both flags, `irq` and `dma_req` are 0, and the stored previous comparator level equals the parameter `PREV_INIT`.
- R2: If `cmp_out` is 1 at a clock edge and was 0 at the previous edge, `up_flag` reads 1 after that edge. The opposite transition sets `dn_flag` in the same way.
- R3: When there is no transition, no clear and no effective DMA completion, a flag keeps its value across the edge.
- R4: `irq` is 1 exactly when `dma_mode` is 0 and (`up_flag` & `up_en` | `dn_flag` & `dn_en`) is 1. It follows changes of the enables in the same cycle.
- R5: A 1 on `up_clr` or `dn_clr` at a clock edge clears the matching flag after that edge.
- R6: When a transition and a clear of the same flag arrive at the same edge, the flag ends up at 1.
- R7: While `dma_mode` is 1, `irq` stays 0 and `dma_req` carries the request term of R4. While `dma_mode` is 0, `dma_req` is 0.
- R8: A `dma_done` pulse while `dma_mode` is 1 clears each flag whose enable is 1. A flag whose enable is 0 keeps its value.
- R9: A `dma_done` pulse while `dma_mode` is 0 has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_out | input | 1 | Filtered comparator output |
| up_en | input | 1 | Enable for rising-edge requests |
| dn_en | input | 1 | Enable for falling-edge requests |
| dma_mode | input | 1 | Routes the request to the DMA engine |
| up_clr | input | 1 | Write-one clear strobe for the rising flag |
| dn_clr | input | 1 | Write-one clear strobe for the falling flag |
| dma_done | input | 1 | Transfer completion pulse from the DMA engine |
| irq | output | 1 | CPU interrupt request |
| dma_req | output | 1 | DMA transfer request |
| up_flag | output | 1 | Rising-edge flag |
| dn_flag | output | 1 | Falling-edge flag |

## Verification
The bench builds the block with `PREV_INIT` at 0. With that value, a comparator held low through reset raises no flag, and the first upward transition after reset is a true edge. Directed steps cover the following cases:
- an edge and a clear arriving at the same edge;
- a DMA completion that arrives while one enable is off;
- a completion that arrives outside DMA mode.

A long run of random stimulus then lets the cycle model compare the flags and both request lines while enables, clears and the mode bit all change at once.

// File: rtl/cmp_edge_req.sv
module cmp_edge_req #(
  parameter bit PREV_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_out,
  input  logic up_en,
  input  logic dn_en,
  input  logic dma_mode,
  input  logic up_clr,
  input  logic dn_clr,
  input  logic dma_done,
  output logic irq,
  output logic dma_req,
  output logic up_flag,
  output logic dn_flag
);

  logic prev_q;
  logic rise, fall, ack, pend;

  assign rise = cmp_out & ~prev_q;
  assign fall = ~cmp_out & prev_q;
  assign ack  = dma_mode & dma_done;
  assign pend = (up_flag & up_en) | (dn_flag & dn_en);

  assign irq     = pend & ~dma_mode;
  assign dma_req = pend & dma_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= PREV_INIT;
      up_flag <= 1'b0;
      dn_flag <= 1'b0;
    end else begin
      prev_q <= cmp_out;
      if (rise)                          up_flag <= 1'b1;
      else if (up_clr || (ack && up_en)) up_flag <= 1'b0;
      if (fall)                          dn_flag <= 1'b1;
      else if (dn_clr || (ack && dn_en)) dn_flag <= 1'b0;
    end
  end

  // R2: a transition raises its flag
  a_r2_up_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_out && !prev_q) |=> up_flag);
  a_r2_dn_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_out && prev_q) |=> dn_flag);

  // R3: flag holds when nothing acts on it
  a_r3_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmp_out && !prev_q) && !up_clr && !(dma_mode && dma_done)) |=> $stable(up_flag));

  // R5: clear without a competing edge
  a_r5_dn_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_clr && !(!cmp_out && prev_q)) |=> !dn_flag);

  // R7: the two request lines are never high together; the CPU line is quiet in DMA mode
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n) !(irq && dma_req));
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n) dma_mode |-> !irq);

  // R8: completion clears the enabled flags
  a_r8_done_up: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && dma_done && up_en && !(cmp_out && !prev_q)) |=> !up_flag);

  // R9: completion outside DMA mode has no effect
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_mode && dma_done && !dn_clr && !(!cmp_out && prev_q)) |=> $stable(dn_flag));

endmodule

// File: tb/tb_cmp_edge_req.sv
module tb_cmp_edge_req;
  localparam int CLK_PERIOD = 10;
  localparam bit PREV_INIT = 1'b0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_out = 0, up_en = 0, dn_en = 0, dma_mode = 0, up_clr = 0, dn_clr = 0, dma_done = 0;
  logic irq, dma_req, up_flag, dn_flag;
  int checks = 0, fails = 0;
  bit finished = 0;

  int m_prev, m_up, m_dn;

  cmp_edge_req #(.PREV_INIT(PREV_INIT)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_out(cmp_out), .up_en(up_en), .dn_en(dn_en),
    .dma_mode(dma_mode), .up_clr(up_clr), .dn_clr(dn_clr), .dma_done(dma_done),
    .irq(irq), .dma_req(dma_req), .up_flag(up_flag), .dn_flag(dn_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = PREV_INIT; m_up = 0; m_dn = 0;
    end else begin
      if (cmp_out && m_prev == 0) m_up = 1;
      else if (up_clr || (dma_mode && dma_done && up_en)) m_up = 0;
      if (!cmp_out && m_prev == 1) m_dn = 1;
      else if (dn_clr || (dma_mode && dma_done && dn_en)) m_dn = 0;
      m_prev = cmp_out;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    int p;
    p = (m_up && up_en) || (m_dn && dn_en);
    chk("R2 up_flag", up_flag, m_up);
    chk("R2 dn_flag", dn_flag, m_dn);
    chk("R4 irq", irq, p && !dma_mode);
    chk("R7 dma_req", dma_req, p && dma_mode);
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    model_cmp();
    up_clr = 0; dn_clr = 0; dma_done = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*3);
    @(negedge clk);
    chk("R1 up_flag", up_flag, 0); chk("R1 dn_flag", dn_flag, 0);
    chk("R1 irq", irq, 0); chk("R1 dma_req", dma_req, 0);
    rst_n = 1;
    cyc();
    chk("R1 no flag after reset", up_flag | dn_flag, 0);

    up_en = 1; cmp_out = 1; cyc();
    chk("R2 rise sets", up_flag, 1); chk("R4 irq on", irq, 1);
    cyc(); cyc();
    chk("R3 held", up_flag, 1); chk("R3 no fall", dn_flag, 0);
    up_en = 0; #1;
    chk("R4 enable off drops irq", irq, 0);
    up_en = 1;
    up_clr = 1; cyc();
    chk("R5 clear", up_flag, 0); chk("R4 irq off", irq, 0);

    dn_en = 1; cmp_out = 0; dn_clr = 1; cyc();
    chk("R6 edge beats clear", dn_flag, 1);

    dma_mode = 1; #1;
    chk("R7 irq quiet", irq, 0); chk("R7 dma_req", dma_req, 1);
    cmp_out = 1; cyc();
    up_en = 0; dma_done = 1; cyc();
    chk("R8 enabled flag cleared", dn_flag, 0);
    chk("R8 disabled flag kept", up_flag, 1);
    chk("R8 request drops", dma_req, 0);

    dma_mode = 0; dn_en = 1; cmp_out = 0; cyc();
    dma_done = 1; up_en = 1; cyc();
    chk("R9 done ignored up", up_flag, 1);
    chk("R9 done ignored dn", dn_flag, 1);

    for (int i = 0; i < 3000; i++) begin
      cmp_out  = ($urandom_range(0, 3) == 0) ? ~cmp_out : cmp_out;
      if ($urandom_range(0, 15) == 0) up_en = ~up_en;
      if ($urandom_range(0, 15) == 0) dn_en = ~dn_en;
      if ($urandom_range(0, 31) == 0) dma_mode = ~dma_mode;
      up_clr   = ($urandom_range(0, 7) == 0);
      dn_clr   = ($urandom_range(0, 7) == 0);
      dma_done = ($urandom_range(0, 5) == 0);
      cyc();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule